// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

The block gives software sixteen general-purpose pins through a 32-bit register port with single-cycle writes and combinational reads. Each pin has an output data bit and a direction bit. Each pin input passes through a two-stage synchroniser and can be read back. On the first thirteen lines, a 3-bit style code per line selects the interrupt condition: a high level, a low level, a rising edge, a falling edge, or either edge.

A detected condition sets a sticky status bit. Software clears that bit by writing a one to it. Each of the thirteen capable lines drives its own active-high interrupt level toward a parent controller for as long as its status bit is set. Because a level condition re-latches on every cycle it holds, the interrupt can only be cleared once the pin has gone inactive. A clock-select register can hand the top two pins to a clock function, which is modelled here as a driven zero.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads zero except the direction register, which reads 0xFFFF. All pins are then inputs (pin_oe = 0) and no interrupt is asserted.
- R2: Accesses are word aligned, at byte offsets 0x00 output data, 0x04 direction, 0x08 input, 0x0C status, 0x10 styles of lines 0-7, 0x14 styles of lines 8-15, 0x18 clock select and 0x1C debounce select. Style registers keep only bits [23:0]. Any address with addr[1:0] != 0 reads 0 and ignores writes. The input register shows a pin value two clock edges after the pin changes.
- R3: A direction bit of 1 makes its line an input (pin_oe low). A direction bit of 0 drives the line's output data bit (pin_oe high, pin_out equal to the data bit).
- R4: Style 0 (active high) and style 1 (active low) set the status bit on every cycle the synchronised level holds. A clear written while the level persists therefore leaves the bit set.
- R5: Style 2 sets status on a 0-to-1 change of the synchronised input, and style 3 on a 1-to-0 change. The status bit is set on the third clock edge after the pin changes.
- R6: Style 4 sets status on both a rising and a falling change.
- R7: Style codes 5, 6 and 7 never set a status bit.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a clear and a new event reach the same status bit in the same cycle, the bit stays set.
- R10: Lines 13, 14 and 15 never set a status bit, whatever their style and input.
- R11: irq[n] is high exactly while status bit n is set, for n in 0..12.
- R12: A nonzero clock-select value forces lines 14 and 15 to pin_oe = 1 and pin_out = 0, overriding their direction and data. A value of zero returns them to normal GPIO use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pin_in | input | 16 | Pin input levels, asynchronous |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin drive enables, high means driving |
| irq | output | 13 | Per-line active-high interrupt levels, lines 0-12 |

## Verification
The assertions assume that wr_en is a clean single-cycle strobe and that addr and wdata are stable around the clock edge. They also assume pin_in is only meaningful after the synchroniser, so no property looks at the raw pins. The bench changes its inputs only on falling clock edges, and it changes pins at least a full cycle apart. This keeps every event one clock wide once synchronised, and it lets the reference model follow the three-edge latency from pin to status exactly. Clears that collide with events are placed deliberately, to exercise the cycle in which both occur.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int NLINE     = 16;
    localparam int NIRQ      = 13;
    localparam int STY_W     = 3;
    localparam int STY_REG_W = 24;
    localparam int DATA_W    = 32;
    localparam int CK_LINE_A = 14;
    localparam int CK_LINE_B = 15;

    // Word index of each register (byte offset / 4)
    localparam logic [2:0] IDX_DOUT  = 3'd0;
    localparam logic [2:0] IDX_DIR   = 3'd1;
    localparam logic [2:0] IDX_DIN   = 3'd2;
    localparam logic [2:0] IDX_STAT  = 3'd3;
    localparam logic [2:0] IDX_STYLO = 3'd4;
    localparam logic [2:0] IDX_STYHI = 3'd5;
    localparam logic [2:0] IDX_CKSEL = 3'd6;
    localparam logic [2:0] IDX_DBSEL = 3'd7;

    typedef enum logic [2:0] {
        STY_LVL_HI = 3'd0,
        STY_LVL_LO = 3'd1,
        STY_RISE   = 3'd2,
        STY_FALL   = 3'd3,
        STY_ANY    = 3'd4
    } style_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } samp_t;

    function automatic logic style_hit(logic [2:0] sty, samp_t s);
        case (sty)
            STY_LVL_HI: return s.cur;
            STY_LVL_LO: return !s.cur;
            STY_RISE:   return s.cur && !s.prev;
            STY_FALL:   return !s.cur && s.prev;
            STY_ANY:    return s.cur ^ s.prev;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_ctrl_detect.sv
module gpio_ctrl_detect
    import gpio_ctrl_pkg::*;
#(
    parameter int N = NIRQ
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     cur,
    input  logic [STY_W*N-1:0] style,
    output logic [N-1:0]     hit
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        samp_t smp;
        assign smp.cur  = cur[g];
        assign smp.prev = prev_q[g];
        assign hit[g]   = style_hit(style[STY_W*g +: STY_W], smp);
    end
endmodule

// File: rtl/gpio_ctrl_status.sv
module gpio_ctrl_status #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    logic [N-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | hit;
    end

    assign stat = stat_q;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(clr & ~hit)) == '0)); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr))); // R8
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(hit)) == $past(hit))); // R9
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NL = NLINE,
    parameter int NI = NIRQ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NL-1:0]     pin_in,
    output logic [NL-1:0]     pin_out,
    output logic [NL-1:0]     pin_oe,
    output logic [NI-1:0]     irq
);
    localparam int STYI_W = STY_W * NI;

    logic [NL-1:0]        dout_q, dir_q, din;
    logic [STY_REG_W-1:0] sty_lo_q, sty_hi_q;
    logic [DATA_W-1:0]    cksel_q, dbsel_q;
    logic [NI-1:0]        hit, clr, stat;
    logic [STYI_W-1:0]    sty_irq;
    logic [NI-1:0]        cur_irq;
    logic [NL-1:0]        stat_ext;
    logic [2:0]           sel;
    logic                 aligned, wr_hit;

    assign sel     = addr[4:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_hit  = wr_en && aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q   <= '0;
            dir_q    <= '1;
            sty_lo_q <= '0;
            sty_hi_q <= '0;
            cksel_q  <= '0;
            dbsel_q  <= '0;
        end else if (wr_hit) begin
            case (sel)
                IDX_DOUT:  dout_q   <= wdata[NL-1:0];
                IDX_DIR:   dir_q    <= wdata[NL-1:0];
                IDX_STYLO: sty_lo_q <= wdata[STY_REG_W-1:0];
                IDX_STYHI: sty_hi_q <= wdata[STY_REG_W-1:0];
                IDX_CKSEL: cksel_q  <= wdata;
                IDX_DBSEL: dbsel_q  <= wdata;
                default: ;
            endcase
        end
    end

    gpio_ctrl_sync #(.W(NL)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(din)
    );

    assign sty_irq = STYI_W'({sty_hi_q, sty_lo_q});
    assign cur_irq = NI'(din);

    gpio_ctrl_detect #(.N(NI)) u_detect (
        .clk(clk), .rst(rst), .cur(cur_irq), .style(sty_irq), .hit(hit)
    );

    assign clr = (wr_hit && sel == IDX_STAT) ? wdata[NI-1:0] : '0;

    gpio_ctrl_status #(.N(NI)) u_status (
        .clk(clk), .rst(rst), .hit(hit), .clr(clr), .stat(stat)
    );

    assign stat_ext = NL'(stat);
    assign irq      = stat;

    always_comb begin
        pin_oe  = ~dir_q;
        pin_out = dout_q;
        if (cksel_q != '0) begin
            pin_oe[CK_LINE_A]  = 1'b1;
            pin_oe[CK_LINE_B]  = 1'b1;
            pin_out[CK_LINE_A] = 1'b0;
            pin_out[CK_LINE_B] = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (sel)
                IDX_DOUT:  rdata = DATA_W'(dout_q);
                IDX_DIR:   rdata = DATA_W'(dir_q);
                IDX_DIN:   rdata = DATA_W'(din);
                IDX_STAT:  rdata = DATA_W'(stat_ext);
                IDX_STYLO: rdata = DATA_W'(sty_lo_q);
                IDX_STYHI: rdata = DATA_W'(sty_hi_q);
                IDX_CKSEL: rdata = cksel_q;
                default:   rdata = dbsel_q;
            endcase
        end
    end

    AST_DIR_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && sel == IDX_DIR) |=> (pin_oe[NI-1:0] == ~$past(wdata[NI-1:0]))); // R3
    AST_CLK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && sel == IDX_CKSEL && wdata != '0) |=> (pin_out[CK_LINE_B:CK_LINE_A] == 2'b00 && pin_oe[CK_LINE_B:CK_LINE_A] == 2'b11)); // R12
endmodule

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [15:0] pin_in = '0;
    logic [31:0] rdata;
    logic [15:0] pin_out, pin_oe;
    logic [12:0] irq;

    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    gpio_ctrl u_gpio_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // behavioural reference model
    logic [15:0] m_out, m_dir, m_s1, m_s2, m_prev, m_stat;
    logic [23:0] m_slo, m_shi;
    logic [31:0] m_ck, m_db;
    logic [23:0] b_slo = '0, b_shi = '0;

    function automatic logic [2:0] m_style(int n);
        return (n < 8) ? m_slo[3*n +: 3] : m_shi[3*(n-8) +: 3];
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return {16'h0, m_out};
            3'd1: return {16'h0, m_dir};
            3'd2: return {16'h0, m_s2};
            3'd3: return {16'h0, m_stat};
            3'd4: return {8'h0, m_slo};
            3'd5: return {8'h0, m_shi};
            3'd6: return m_ck;
            default: return m_db;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [15:0] hit;
        cyc++;
        if (rst) begin
            m_out = '0; m_dir = '1; m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
            m_slo = '0; m_shi = '0; m_ck = '0; m_db = '0;
        end else begin
            hit = '0;
            for (int n = 0; n < 13; n++) begin
                case (m_style(n))
                    3'd0: hit[n] = m_s2[n];
                    3'd1: hit[n] = !m_s2[n];
                    3'd2: hit[n] = m_s2[n] && !m_prev[n];
                    3'd3: hit[n] = !m_s2[n] && m_prev[n];
                    3'd4: hit[n] = m_s2[n] != m_prev[n];
                    default: hit[n] = 1'b0;
                endcase
            end
            if (wr_en && addr == 5'h0C) m_stat = (m_stat & ~wdata[15:0]) | hit;
            else                        m_stat = m_stat | hit;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (wr_en && addr[1:0] == 2'b00) begin
                case (addr[4:2])
                    3'd0: m_out = wdata[15:0];
                    3'd1: m_dir = wdata[15:0];
                    3'd4: m_slo = wdata[23:0];
                    3'd5: m_shi = wdata[23:0];
                    3'd6: m_ck  = wdata;
                    3'd7: m_db  = wdata;
                    default: ;
                endcase
            end
        end
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare with the model on every cycle, away from the edge
    always @(negedge clk) begin
        logic [15:0] e_oe, e_out;
        #1;
        if (cyc > 0) begin
            e_oe = ~m_dir; e_out = m_out;
            if (m_ck != 0) begin e_oe[15:14] = 2'b11; e_out[15:14] = 2'b00; end
            check(rdata == m_read(addr), "R2 read", rdata, m_read(addr));
            check(pin_oe == e_oe, "R3/R12 oe", {16'h0, pin_oe}, {16'h0, e_oe});
            check(pin_out == e_out, "R3/R12 out", {16'h0, pin_out}, {16'h0, e_out});
            check(irq == m_stat[12:0], "R11 irq", {19'h0, irq}, {19'h0, m_stat[12:0]});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); addr = a; #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_style(input int line, input logic [2:0] code);
        if (line < 8) begin b_slo[3*line +: 3] = code; wr(5'h10, {8'h0, b_slo}); end
        else begin b_shi[3*(line-8) +: 3] = code; wr(5'h14, {8'h0, b_shi}); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_expect(5'h04, 32'h0000FFFF, "R1 dir reset");
        rd_expect(5'h00, 32'h0, "R1 dout reset");
        check(pin_oe == 16'h0 && irq == 13'h0, "R1 pins/irq reset", {pin_oe, 3'b0, irq}, 32'h0);
        rst = 1'b0;
        tick(2);
        // R7 all styles none, toggle everything
        b_slo = 24'hB6DB6D; b_shi = 24'hB6DB6D;
        wr(5'h10, {8'h0, b_slo}); wr(5'h14, {8'h0, b_shi});
        set_pins(16'hFFFF); tick(4); set_pins(16'h0000); tick(4);
        rd_expect(5'h0C, 32'h0, "R7 codes 5-7 silent");
        set_style(0, 3'd6); set_style(1, 3'd7);
        set_pins(16'h0003); tick(4);
        rd_expect(5'h0C, 32'h0, "R7 codes 6,7 silent");
        set_pins(16'h0000); tick(3);
        // R3 direction and data
        wr(5'h00, 32'h0000A5A5); wr(5'h04, 32'h00000F0F);
        tick(1);
        check(pin_oe == 16'hF0F0, "R3 oe from dir", {16'h0, pin_oe}, 32'h0000F0F0);
        check((pin_out & pin_oe) == 16'hA0A0, "R3 driven data", {16'h0, pin_out & pin_oe}, 32'h0000A0A0);
        wr(5'h04, 32'h0000FFFF);
        // R4 active-high level relatch
        set_style(0, 3'd0);
        set_pins(16'h0001); tick(4);
        rd_expect(5'h0C, 32'h1, "R4 high level sets");
        wr(5'h0C, 32'h1);
        rd_expect(5'h0C, 32'h1, "R4 clear while high relatches");
        set_pins(16'h0000); tick(4);
        wr(5'h0C, 32'h1);
        rd_expect(5'h0C, 32'h0, "R4 clear after release");
        // R4 active-low
        set_pins(16'h0002); tick(3);
        set_style(1, 3'd1); tick(2);
        rd_expect(5'h0C, 32'h0, "R4 low style idle while high");
        set_pins(16'h0000); tick(4);
        rd_expect(5'h0C, 32'h2, "R4 low level sets");
        set_pins(16'h0002); tick(4);
        wr(5'h0C, 32'h2);
        rd_expect(5'h0C, 32'h0, "R4 low cleared");
        // R5 rising and falling
        set_style(2, 3'd2); set_style(3, 3'd3);
        set_pins(16'h000E); tick(4);
        rd_expect(5'h0C, 32'h4, "R5 rising only");
        // R8 write zero keeps, one clears
        wr(5'h0C, 32'h0);
        rd_expect(5'h0C, 32'h4, "R8 zero write keeps");
        check(irq == 13'h4, "R11 irq line 2", {19'h0, irq}, 32'h4);
        wr(5'h0C, 32'h4);
        rd_expect(5'h0C, 32'h0, "R8 one write clears");
        set_pins(16'h0002); tick(4);
        rd_expect(5'h0C, 32'h8, "R5 falling only");
        wr(5'h0C, 32'h8);
        // R5 latency: third edge after pin change
        set_pins(16'h0006);
        tick(2); addr = 5'h0C; #1;
        check(rdata == 32'h0, "R5 not yet at edge 2", rdata, 32'h0);
        tick(1); #1;
        check(rdata == 32'h4, "R5 set at edge 3", rdata, 32'h4);
        wr(5'h0C, 32'h4);
        set_pins(16'h0002); tick(4);
        wr(5'h0C, 32'h8);
        // R6 both edges
        set_style(4, 3'd4);
        set_pins(16'h0012); tick(4);
        rd_expect(5'h0C, 32'h10, "R6 rise");
        wr(5'h0C, 32'h10);
        set_pins(16'h0002); tick(4);
        rd_expect(5'h0C, 32'h10, "R6 fall");
        wr(5'h0C, 32'h10);
        // R9 clear collides with new event
        set_style(5, 3'd2);
        set_pins(16'h0022);
        @(negedge clk);
        wr(5'h0C, 32'h20);
        rd_expect(5'h0C, 32'h20, "R9 event beats clear");
        wr(5'h0C, 32'h20);
        rd_expect(5'h0C, 32'h0, "R9 later clear");
        // R10 high lines never latch
        set_style(13, 3'd0); set_style(14, 3'd0); set_style(15, 3'd4);
        set_pins(16'hE002); tick(4);
        set_pins(16'h2002); tick(4);
        rd_expect(5'h0C, 32'h0, "R10 lines 13-15 silent");
        // R12 clock release
        wr(5'h00, 32'h0000C000); wr(5'h04, 32'h00003FFF);
        tick(1);
        check(pin_out[15:14] == 2'b11, "R12 gpio use", {30'h0, pin_out[15:14]}, 32'h3);
        wr(5'h18, 32'h00000001); tick(1);
        check(pin_out[15:14] == 2'b00 && pin_oe[15:14] == 2'b11, "R12 clock use",
              {28'h0, pin_oe[15:14], pin_out[15:14]}, 32'hC);
        wr(5'h18, 32'h0); tick(1);
        check(pin_out[15:14] == 2'b11, "R12 released", {30'h0, pin_out[15:14]}, 32'h3);
        // R2 map details
        wr(5'h1C, 32'hDEADBEEF);
        rd_expect(5'h1C, 32'hDEADBEEF, "R2 debounce select rw");
        wr(5'h10, 32'hFFFFFFFF);
        rd_expect(5'h10, 32'h00FFFFFF, "R2 style upper bits zero");
        wr(5'h10, 32'h00B6DB6D); wr(5'h14, 32'h00B6DB6D);
        wr(5'h1D, 32'h12345678);
        rd_expect(5'h1C, 32'hDEADBEEF, "R2 misaligned write ignored");
        rd_expect(5'h1D, 32'h0, "R2 misaligned read zero");
        set_pins(16'h1234); tick(2); addr = 5'h08; #1;
        check(rdata == 32'h1234, "R2 input after two edges", rdata, 32'h1234);
        tick(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule